// File: doc/BRIEF.md
# Programmable Power-of-Two Delay Divider

This block is the delay counter at the core of a one-shot timer. A chain of equal counter sections advances on a count strobe, and a select code picks which stage marks the end of the delay. When the strobe arrives with every bit below that stage set, the block emits a one-cycle terminal-count pulse and the counted bits wrap to zero. The pulse-shaping logic drives a synchronous clear whenever it starts or restarts a delay.

The most significant select bit picks between two layouts. When it is high, the sections form one long chain. The remaining select bits place the tap inside the top section, so ratios run from 2^((S-1)*W+1) to 2^(S*W). When it is low, every section counts on each strobe as an independent counter, with the same ratio of 2 to 2^W, and the terminal count comes from the lowest section. Split mode is the normal setting for short delays. Its other use is to load the whole chain with ones in 2^W - 1 strobes, so that a single strobe in chain mode then checks the longest ratio.

Top module: `delay_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count` becomes zero and `tc` becomes low at that edge.
- R2: With `sel` MSB high (chain mode), the low select bits read as value m set k = (SECTIONS-1)*SECT_W + m + 1. On each strobe, `count` becomes (count + 1) mod 2^k, which also clears every bit at or above k. `tc` is high after the strobe that finds bits [k-1:0] all ones, so from zero the ratio is 2^k.
- R3: With `sel` MSB low (split mode), let j = m + 1. Section i occupies `count[i*SECT_W +: SECT_W]`, and each section independently becomes (section + 1) mod 2^j on every strobe. `tc` is high after the strobe that finds bits [j-1:0] of section 0 all ones.
- R4: In split mode with all low select bits high, 2^SECT_W - 1 strobes from zero set every bit of `count`. A following strobe with all select bits high then raises `tc` and returns `count` to zero.
- R5: `clr` high at a clock edge zeroes `count` and holds `tc` low, even when `step` is also high.
- R6: Without `step` or `clr`, `count` keeps its value and `tc` stays low.
- R7: `tc` is registered. It is high for exactly the one cycle after the clock edge that sampled the completing strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| clr | input | 1 | Synchronous clear from the trigger logic; wins over `step` |
| step | input | 1 | Count strobe, one count per cycle it is high |
| sel | input | $clog2(SECT_W)+1 | MSB: 1 chain, 0 split; low bits: tap position m |
| count | output | SECT_W*SECTIONS | Stage values, section i at bits [i*SECT_W +: SECT_W] |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bench builds the block with SECT_W = 4 and SECTIONS = 3, which gives a 12-bit chain and a 3-bit select. The longest chain ratio is then 4096 strobes, so the bench can run it in full from zero and also reach it through the split-mode preload, and the two routes can be compared. The same parameters keep the cross-section carries, the clearing of bits above a short tap after the mode changes, and every split ratio within a few thousand cycles.

// File: rtl/delay_div_pkg.sv
// Shared types and helpers for the power-of-two delay divider.
// Assumes section widths are powers of two so a select field spans them exactly.
package delay_div_pkg;

    // Layout chosen by the most significant select bit.
    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_CHAIN = 1'b1
    } div_mode_e;

    // True when a bit position lies under the selected tap span.
    function automatic logic below_tap(input int unsigned bitpos, input int unsigned span);
        return bitpos < span;
    endfunction

endpackage

// File: rtl/div_mask_gen.sv
// Decodes the select code into a per-section count mask.
// Chain mode: lower sections fully enabled, top section limited to the tap span.
// Split mode: every section limited to the same tap span.
// Assumes SECT_W is a power of two and SEL_W = $clog2(SECT_W)+1.
module div_mask_gen
    import delay_div_pkg::*;
#(
    parameter int SECT_W   = 8,
    parameter int SECTIONS = 3,
    localparam int SEL_W   = $clog2(SECT_W) + 1,
    localparam int TOTAL_W = SECT_W * SECTIONS
) (
    input  logic [SEL_W-1:0]   sel,
    output div_mode_e          mode,
    output logic [TOTAL_W-1:0] mask
);

    localparam int LOW_W = SEL_W - 1;

    logic [SEL_W-1:0] span;

    // Mode from the top select bit, span = low bits + 1 (1..SECT_W).
    always_comb begin
        mode = div_mode_e'(sel[SEL_W-1]);
        span = {1'b0, sel[LOW_W-1:0]} + SEL_W'(1);
    end

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
        for (genvar b = 0; b < SECT_W; b++) begin : g_bit
            if (s == SECTIONS - 1) begin : g_top
                // Top section is limited in both modes.
                assign mask[s*SECT_W + b] = below_tap(b, int'(span));
            end else begin : g_low
                // Lower sections are fully enabled only when chained.
                assign mask[s*SECT_W + b] = (mode == MODE_CHAIN) ? 1'b1
                                          : below_tap(b, int'(span));
            end
        end
    end

endmodule

// File: rtl/div_section.sv
// One counter section of the divider chain.
// On a strobe it loads (q+1)&mask when its carry input is set, else q&mask,
// so bits outside the mask are cleared by any strobe.
// full reports that every masked bit is one.
module div_section #(
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              carry_in,
    input  logic [SECT_W-1:0] mask,
    output logic [SECT_W-1:0] q,
    output logic              full
);

    logic [SECT_W-1:0] q_next;

    // Next value for a strobe: increment or hold, both confined to the mask.
    always_comb begin
        if (carry_in) begin
            q_next = (q + SECT_W'(1)) & mask;
        end else begin
            q_next = q & mask;
        end
        full = ((q & mask) == mask);
    end

    // Section register with reset, clear priority and strobe enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (step) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/delay_divider.sv
// Programmable power-of-two delay divider.
// Sections are chained or run in parallel by the select MSB; the tap inside
// the top (or each) section is set by the low select bits. tc is a registered
// one-cycle pulse on the strobe that completes the selected ratio.
// Assumes SECT_W is a power of two; reset is synchronous, active low.
module delay_divider
    import delay_div_pkg::*;
#(
    parameter int SECT_W   = 8,
    parameter int SECTIONS = 3,
    localparam int SEL_W   = $clog2(SECT_W) + 1,
    localparam int TOTAL_W = SECT_W * SECTIONS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [SEL_W-1:0]   sel,
    output logic [TOTAL_W-1:0] count,
    output logic               tc
);

    div_mode_e             mode;
    logic [TOTAL_W-1:0]    mask;
    logic [SECTIONS-1:0]   carry;
    logic [SECTIONS-1:0]   full;
    logic                  hit;

    div_mask_gen #(
        .SECT_W  (SECT_W),
        .SECTIONS(SECTIONS)
    ) u_mask (
        .sel (sel),
        .mode(mode),
        .mask(mask)
    );

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        if (s == 0) begin : g_first
            // Lowest section always counts on a strobe.
            assign carry[s] = 1'b1;
        end else begin : g_next
            // Chain: ripple on full lower sections; split: count every strobe.
            assign carry[s] = (mode == MODE_SPLIT) ? 1'b1 : (carry[s-1] & full[s-1]);
        end

        div_section #(
            .SECT_W(SECT_W)
        ) u_sec (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .step    (step),
            .carry_in(carry[s]),
            .mask    (mask[s*SECT_W +: SECT_W]),
            .q       (count[s*SECT_W +: SECT_W]),
            .full    (full[s])
        );
    end

    // Terminal condition: lowest section in split mode, whole chain otherwise.
    always_comb begin
        if (mode == MODE_SPLIT) begin
            hit = full[0];
        end else begin
            hit = carry[SECTIONS-1] & full[SECTIONS-1];
        end
    end

    // Terminal-count pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= 1'b0;
        end else if (clr) begin
            tc <= 1'b0;
        end else begin
            tc <= step & hit;
        end
    end

endmodule

// File: rtl/delay_divider_chk.sv
// Property checker for delay_divider, attached by bind below.
module delay_divider_chk #(
    parameter int TOTAL_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic               step,
    input logic [TOTAL_W-1:0] count,
    input logic               tc
);

    // R1: reset empties the counter and silences tc.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !tc));

    // R5: clear wins over any strobe.
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !tc));

    // R6: no strobe, no change and no pulse.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> ($stable(count) && !tc));

    // R7: pulse lasts one cycle.
    p_tc_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    // R7: pulse only follows a sampled strobe.
    p_tc_after_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> $past(step));

    // R2: a completed ratio always leaves stage zero cleared.
    p_tc_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> !count[0]);

endmodule

bind delay_divider delay_divider_chk #(.TOTAL_W(TOTAL_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .step (step),
    .count(count),
    .tc   (tc)
);

// File: tb/delay_divider_tb.sv
// Scoreboard bench: the driver computes expected values from the requirements
// and queues them; the monitor pops and compares after each clock edge.
module delay_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SW   = 4;
    localparam int NS   = 3;
    localparam int SELW = $clog2(SW) + 1;
    localparam int TW   = SW * NS;
    localparam int WATCHDOG = 40000;

    typedef struct {
        logic [TW-1:0] cnt;
        logic          tc;
        string         tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            step = 1'b0;
    logic [SELW-1:0] sel = '0;
    logic [TW-1:0]   count;
    logic            tc;

    exp_t            sb[$];
    logic [TW-1:0]   m_cnt = '0;
    logic            m_tc = 1'b0;
    int              checks = 0;
    int              fails = 0;
    int              tc_seen = 0;
    bit              done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    delay_divider #(.SECT_W(SW), .SECTIONS(NS)) u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (step),
        .sel  (sel),
        .count(count),
        .tc   (tc)
    );

    // Reference model written from R1..R6.
    function automatic void model(input logic r, input logic c, input logic s,
                                  input logic [SELW-1:0] code);
        int j;
        logic [TW-1:0] m;
        logic full;
        j = int'(code[SELW-2:0]) + 1;
        if (!r || c) begin
            m_cnt = '0;
            m_tc  = 1'b0;
        end else if (!s) begin
            m_tc = 1'b0;
        end else if (code[SELW-1]) begin
            m = TW'((64'(1) << ((NS-1)*SW + j)) - 64'(1));
            full = ((m_cnt & m) == m);
            m_cnt = (m_cnt + TW'(1)) & m;
            m_tc = full;
        end else begin
            m_tc = 1'b0;
            for (int x = 0; x < NS; x++) begin
                logic [SW-1:0] sub, ms;
                ms  = SW'((1 << j) - 1);
                sub = m_cnt[x*SW +: SW];
                if (x == 0) m_tc = ((sub & ms) == ms);
                m_cnt[x*SW +: SW] = (sub + SW'(1)) & ms;
            end
        end
    endfunction

    // Driver: apply one cycle of inputs and queue the expected result.
    task automatic drive(input logic r, input logic c, input logic s,
                         input logic [SELW-1:0] code, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r;
        clr   = c;
        step  = s;
        sel   = code;
        model(r, c, s, code);
        e.cnt = m_cnt;
        e.tc  = m_tc;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic run_steps(input int n, input logic [SELW-1:0] code, input string tag);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b1, code, tag);
    endtask

    // Monitor: compare one queued item just after every rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (tc === 1'b1) tc_seen++;
            if (count !== e.cnt || tc !== e.tc) begin
                fails++;
                $display("FAIL %s: count=%0h tc=%0b expected count=%0h tc=%0b",
                         e.tag, count, tc, e.cnt, e.tc);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int tc_before;
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b1, 3'b111, "R1 reset");

        // R3: split mode, ratio 2, all sections count
        run_steps(6, 3'b000, "R3 split ratio 2");

        // R6: idle cycles hold the value
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 3'b000, "R6 hold");

        // R3: split ratio 8 with gaps between strobes (R6 in the gaps)
        drive(1'b1, 1'b1, 1'b0, 3'b010, "R5 clear");
        for (int i = 0; i < 20; i++) begin
            drive(1'b1, 1'b0, 1'b1, 3'b010, "R3 split ratio 8");
            drive(1'b1, 1'b0, 1'b0, 3'b010, "R6 gap hold");
        end

        // R2: chain mode after split values: upper bits cleared, ratio 512
        run_steps(520, 3'b100, "R2 chain ratio 512");

        // R5: clear together with a strobe
        drive(1'b1, 1'b1, 1'b1, 3'b100, "R5 clear beats step");
        drive(1'b1, 1'b0, 1'b0, 3'b100, "R5 stays zero");

        // R4: preload all ones in split mode, then one chained strobe
        run_steps(15, 3'b011, "R4 preload");
        drive(1'b1, 1'b0, 1'b0, 3'b011, "R4 preload hold");
        tc_before = tc_seen;
        drive(1'b1, 1'b0, 1'b1, 3'b111, "R4 full ratio via preload");
        drive(1'b1, 1'b0, 1'b0, 3'b111, "R7 pulse ends");
        drive(1'b1, 1'b0, 1'b0, 3'b111, "R7 idle");
        // R4: exactly one pulse from the preload strobe
        checks++;
        if (tc_seen - tc_before != 1) begin
            fails++;
            $display("FAIL R4: pulses=%0d expected=1", tc_seen - tc_before);
        end

        // R2: full 4096 ratio from zero, back-to-back strobes (R7 single pulse)
        tc_before = tc_seen;
        run_steps(4097, 3'b111, "R2 chain ratio 4096");
        drive(1'b1, 1'b0, 1'b0, 3'b111, "R7 settle");
        drive(1'b1, 1'b0, 1'b0, 3'b111, "R7 settle");
        // R7: one pulse per completed ratio
        checks++;
        if (tc_seen - tc_before != 1) begin
            fails++;
            $display("FAIL R7: pulses=%0d expected=1", tc_seen - tc_before);
        end

        // R2: switch to a shorter chain tap with a high value in place
        run_steps(40, 3'b101, "R2 chain ratio 1024 after 4096");

        // R3: split ratio 16 on all sections
        run_steps(35, 3'b011, "R3 split ratio 16");

        // R1: reset in the middle of a run
        drive(1'b0, 1'b0, 1'b1, 3'b011, "R1 reset mid-run");
        run_steps(3, 3'b011, "R3 restart");

        drive(1'b1, 1'b0, 1'b0, 3'b011, "R6 final hold");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule